// File: doc/BRIEF.md
# BCD Calendar Counter with Hold

This block keeps wall-clock time and date as packed BCD fields: seconds, minutes, hours, day of month, month, two-digit year and a 3-bit day-of-week. It counts one second for each one-cycle pulse from an external 1 Hz prescaler. It runs in either 24-hour or 12-hour mode; in 12-hour mode a separate flag marks the afternoon half. The month length follows the calendar, and every year divisible by four counts as a leap year.

Software controls the counter through level inputs (run, hour mode, hold), a one-cycle adjust command and a field write port. The write port has one strobe per field and shares one data byte. Hold freezes the visible fields so they can be read as a coherent set. A second that arrives during hold is remembered and added when hold is released. The adjust command rounds the time to the nearest whole minute. A busy output rises for one cycle after each count step while the carries settle. Field writes and adjust commands made in that cycle are dropped.

Top module: `bcd_calendar`

## Requirements
- R1: Synchronous active-low reset gives the following state: seconds 0x00, minutes 0x00, hour 0x12 with the PM flag 0, day 0x01, month 0x01, year 0x00, day-of-week 0 and busy 0.
- R2: While `run_i` is 0, tick pulses change no field, raise no busy and are not remembered for later.
- R3: Each counted tick adds one second. Seconds and minutes count in BCD from 00 to 59. Passing 59 returns the field to 00 and carries into the next field.
- R4: With `mode24_i` = 1, hours count 00 to 23. Passing 23:59:59 gives 00:00:00 and advances the date.
- R5: With `mode24_i` = 0, hours run 12, 01, 02 … 11. The PM flag toggles when the hour passes 11 into 12. The date advances only on the step from PM 11:59:59 to AM 12:00:00.
- R6: A day carry past the last day of the month sets the day to 01 and advances the month. The last day is 31, 30 for months 04/06/09/11, and for month 02 it is 29 when the year value is divisible by 4 and 28 otherwise. Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R7: Day-of-week advances on every day carry and wraps from 6 to 0. It does not depend on the day-of-month value.
- R8: `busy_o` is 1 for exactly the cycle after each count step (counted tick, hold release with a remembered second, or accepted adjust). A field write or adjust command presented while `busy_o` is 1 is ignored.
- R9: While `hold_i` is 1, no field advances. If one or more ticks arrive during hold, exactly one second is added, with full carries, in the clock cycle that samples `hold_i` low.
- R10: An adjust pulse with seconds 00–29 sets seconds to 00. With seconds 30–59 it sets seconds to 00 and adds one minute with full carry propagation.
- R11: Strobe bit i of `wr_stb_i` loads one field from `wr_data_i`, visible on the next cycle. The fields by bit are 0 seconds [6:0], 1 minutes [6:0], 2 hour [5:0] with the PM flag from bit 7, 3 day [5:0], 4 month [4:0], 5 year [7:0] and 6 day-of-week [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per second from the prescaler |
| run_i | input | 1 | Counting enable |
| mode24_i | input | 1 | 1 = 24-hour counting, 0 = 12-hour counting |
| hold_i | input | 1 | Freeze visible count for coherent reads |
| adjust_i | input | 1 | One-cycle round-to-minute command |
| wr_stb_i | input | 7 | Per-field write strobes (bit map in R11) |
| wr_data_i | input | 8 | Shared write data |
| sec_o | output | 7 | Seconds, BCD |
| min_o | output | 7 | Minutes, BCD |
| hour_o | output | 6 | Hours, BCD |
| pm_o | output | 1 | Afternoon flag (12-hour mode) |
| day_o | output | 6 | Day of month, BCD |
| mon_o | output | 5 | Month, BCD |
| year_o | output | 8 | Year 00–99, BCD |
| wday_o | output | 3 | Day of week 0–6 |
| busy_o | output | 1 | Carry settling; writes and adjust ignored |

## Verification
The bench computes every expected field in binary arithmetic and compares it with the BCD value from the design. It sweeps the end of every month of all 100 years, and also the day before each month end. A design with a wrong leap rule or month table would step into an impossible date such as February 29 in a non-leap year, or skip a real date. Every hour is swept in both modes, with the PM flag in both states. This catches a 12-hour counter that reaches 00 or 13, that toggles PM at the 12 to 01 step, or that advances the date at noon. The bench also checks the cases that are easy to get wrong. A second during hold must be added on release, including the release that rolls the whole date. An adjust at 29 must round down and one at 30 must round up. A write or adjust issued in the busy cycle must be dropped rather than overwrite the freshly carried value.

// File: rtl/cal_pkg.sv
// Package cal_pkg: field widths, write-strobe indices and the packed time
// record shared by the calendar counter and its helpers.
// Assumes every field is packed BCD (tens digit above units digit).
package cal_pkg;
    localparam int SEC_W   = 7;
    localparam int MIN_W   = 7;
    localparam int HOUR_W  = 6;
    localparam int DAY_W   = 6;
    localparam int MON_W   = 5;
    localparam int YEAR_W  = 8;
    localparam int WDAY_W  = 3;
    localparam int DATA_W  = 8;

    localparam int FLD_SEC  = 0;
    localparam int FLD_MIN  = 1;
    localparam int FLD_HOUR = 2;
    localparam int FLD_DAY  = 3;
    localparam int FLD_MON  = 4;
    localparam int FLD_YEAR = 5;
    localparam int FLD_WDAY = 6;
    localparam int NUM_FIELDS = 7;

    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic [MIN_W-1:0]  min;
        logic              pm;
        logic [HOUR_W-1:0] hour;
        logic [DAY_W-1:0]  day;
        logic [MON_W-1:0]  mon;
        logic [YEAR_W-1:0] year;
        logic [WDAY_W-1:0] wday;
    } cal_time_t;

    localparam cal_time_t RESET_TIME = '{
        sec: 7'h00, min: 7'h00, pm: 1'b0, hour: 6'h12,
        day: 6'h01, mon: 5'h01, year: 8'h00, wday: 3'd0
    };
endpackage

// File: rtl/cal_bcd_wrap.sv
// Module cal_bcd_wrap: one counter field that steps by one and wraps from
// a run-time upper bound back to a run-time lower bound.
// Assumes val holds a legal BCD value (units digit 0-9) when W > 4; fields
// of four bits or fewer are treated as a plain binary digit.
module cal_bcd_wrap #(
    parameter int W = 7
) (
    input  logic [W-1:0] val,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    input  logic         inc,
    output logic [W-1:0] nxt,
    output logic         carry
);
    logic [W-1:0] bump;
    logic         at_top;

    generate
        if (W > 4) begin : g_bcd
            logic [W-5:0] tens;
            assign tens = val[W-1:4];
            // Two-digit BCD increment: units roll 9 -> 0 into the tens digit.
            assign bump = (val[3:0] == 4'd9) ? {tens + 1'b1, 4'd0}
                                             : {tens, val[3:0] + 4'd1};
        end else begin : g_bin
            // Single digit: plain binary increment.
            assign bump = val + 1'b1;
        end
    endgenerate

    assign at_top = (val == hi);
    assign carry  = inc && at_top;

    // Select the stepped or wrapped value only when asked to step.
    always_comb begin
        if (!inc)       nxt = val;
        else if (at_top) nxt = lo;
        else            nxt = bump;
    end
endmodule

// File: rtl/cal_month_len.sv
// Module cal_month_len: last day (BCD) of a month for a two-digit BCD year.
// Assumes a leap year whenever the year value is divisible by four.
module cal_month_len
    import cal_pkg::*;
(
    input  logic [MON_W-1:0]  mon,
    input  logic [YEAR_W-1:0] year,
    output logic [DAY_W-1:0]  last_day
);
    logic [1:0] rem4;
    logic       leap;
    logic       unused_year;

    // (10*tens + units) mod 4 equals (2*tens + units) mod 4.
    assign rem4        = {year[4], 1'b0} + year[1:0];
    assign leap        = (rem4 == 2'd0);
    assign unused_year = ^{year[7:5], year[3:2]};

    // Month table.
    always_comb begin
        case (mon)
            5'h02:                      last_day = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
            default:                    last_day = 6'h31;
        endcase
    end
endmodule

// File: rtl/cal_hour_step.sv
// Module cal_hour_step: hour field step in 24-hour or 12-hour counting,
// including the half-day flag and the carry into the date.
// Assumes the hour is legal for the selected mode (00-23 or 01-12).
module cal_hour_step
    import cal_pkg::*;
(
    input  logic [HOUR_W-1:0] hour,
    input  logic              pm,
    input  logic              mode24,
    input  logic              inc,
    output logic [HOUR_W-1:0] nhour,
    output logic              npm,
    output logic              day_carry
);
    logic [HOUR_W-1:0] lo, hi;
    logic              wrap_c;
    logic              at_eleven;

    assign lo = mode24 ? 6'h00 : 6'h01;
    assign hi = mode24 ? 6'h23 : 6'h12;

    cal_bcd_wrap #(.W(HOUR_W)) u_hour (
        .val(hour), .lo(lo), .hi(hi), .inc(inc), .nxt(nhour), .carry(wrap_c)
    );

    assign at_eleven = inc && !mode24 && (hour == 6'h11);

    // Half-day flag flips on 11 -> 12; date moves at 24h wrap or PM 11 -> AM 12.
    always_comb begin
        npm       = at_eleven ? !pm : pm;
        day_carry = mode24 ? wrap_c : (at_eleven && pm);
    end
endmodule

// File: rtl/bcd_calendar.sv
// Module bcd_calendar: BCD time-of-day and date counter with run, hold
// (one remembered second), round-to-minute adjust and per-field writes.
// Assumes tick_i pulses are at least two cycles apart and that software
// writes only legal BCD values for the active hour mode.
module bcd_calendar
    import cal_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_i,
    input  logic                  run_i,
    input  logic                  mode24_i,
    input  logic                  hold_i,
    input  logic                  adjust_i,
    input  logic [NUM_FIELDS-1:0] wr_stb_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    output logic [SEC_W-1:0]      sec_o,
    output logic [MIN_W-1:0]      min_o,
    output logic [HOUR_W-1:0]     hour_o,
    output logic                  pm_o,
    output logic [DAY_W-1:0]      day_o,
    output logic [MON_W-1:0]      mon_o,
    output logic [YEAR_W-1:0]     year_o,
    output logic [WDAY_W-1:0]     wday_o,
    output logic                  busy_o
);
    localparam logic [SEC_W-1:0] SEC_HALF = 7'h30;
    localparam logic [SEC_W-1:0] SEC_LAST = 7'h59;

    cal_time_t cur_q, base, nxt_d;
    logic busy_q, pend_q, pend_d;
    logic tick_ok, do_adj, adj_up, step, inc;
    logic c_sec, c_min, c_hr, c_day, c_mon;
    logic unused_carry_year, unused_carry_wday, unused_data;
    logic [SEC_W-1:0]  n_sec;
    logic [MIN_W-1:0]  n_min;
    logic [HOUR_W-1:0] n_hour;
    logic              n_pm;
    logic [DAY_W-1:0]  n_day, last_day;
    logic [MON_W-1:0]  n_mon;
    logic [YEAR_W-1:0] n_year;
    logic [WDAY_W-1:0] n_wday;

    assign tick_ok = tick_i && run_i;
    assign do_adj  = adjust_i && !busy_q;
    assign adj_up  = do_adj && (cur_q.sec >= SEC_HALF);
    assign step    = !hold_i && (pend_q || tick_ok) && !do_adj;
    assign inc     = step || adj_up;

    // Remembered second: set in hold or under adjust, consumed by a step.
    always_comb begin
        if (hold_i || do_adj) pend_d = pend_q || tick_ok;
        else                  pend_d = pend_q && tick_ok;
    end

    // Adjust rewrites seconds before the chain; rounding up reuses one step from 59.
    always_comb begin
        base = cur_q;
        if (do_adj) base.sec = adj_up ? SEC_LAST : '0;
    end

    cal_bcd_wrap #(.W(SEC_W)) u_sec (
        .val(base.sec), .lo(7'h00), .hi(SEC_LAST), .inc(inc),
        .nxt(n_sec), .carry(c_sec));
    cal_bcd_wrap #(.W(MIN_W)) u_min (
        .val(base.min), .lo(7'h00), .hi(7'h59), .inc(c_sec),
        .nxt(n_min), .carry(c_min));
    cal_hour_step u_hour (
        .hour(base.hour), .pm(base.pm), .mode24(mode24_i), .inc(c_min),
        .nhour(n_hour), .npm(n_pm), .day_carry(c_hr));
    cal_month_len u_len (
        .mon(base.mon), .year(base.year), .last_day(last_day));
    cal_bcd_wrap #(.W(DAY_W)) u_day (
        .val(base.day), .lo(6'h01), .hi(last_day), .inc(c_hr),
        .nxt(n_day), .carry(c_day));
    cal_bcd_wrap #(.W(MON_W)) u_mon (
        .val(base.mon), .lo(5'h01), .hi(5'h12), .inc(c_day),
        .nxt(n_mon), .carry(c_mon));
    cal_bcd_wrap #(.W(YEAR_W)) u_year (
        .val(base.year), .lo(8'h00), .hi(8'h99), .inc(c_mon),
        .nxt(n_year), .carry(unused_carry_year));
    cal_bcd_wrap #(.W(WDAY_W)) u_wday (
        .val(base.wday), .lo(3'd0), .hi(3'd6), .inc(c_hr),
        .nxt(n_wday), .carry(unused_carry_wday));

    assign unused_data = wr_data_i[6];

    // Assemble the stepped record, then let accepted field writes override it.
    always_comb begin
        nxt_d = '{sec: n_sec, min: n_min, pm: n_pm, hour: n_hour,
                  day: n_day, mon: n_mon, year: n_year, wday: n_wday};
        if (!busy_q) begin
            if (wr_stb_i[FLD_SEC])  nxt_d.sec  = wr_data_i[SEC_W-1:0];
            if (wr_stb_i[FLD_MIN])  nxt_d.min  = wr_data_i[MIN_W-1:0];
            if (wr_stb_i[FLD_HOUR]) begin
                nxt_d.hour = wr_data_i[HOUR_W-1:0];
                nxt_d.pm   = wr_data_i[DATA_W-1];
            end
            if (wr_stb_i[FLD_DAY])  nxt_d.day  = wr_data_i[DAY_W-1:0];
            if (wr_stb_i[FLD_MON])  nxt_d.mon  = wr_data_i[MON_W-1:0];
            if (wr_stb_i[FLD_YEAR]) nxt_d.year = wr_data_i[YEAR_W-1:0];
            if (wr_stb_i[FLD_WDAY]) nxt_d.wday = wr_data_i[WDAY_W-1:0];
        end
    end

    // State registers: time record, remembered second, busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= RESET_TIME;
            pend_q <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            cur_q  <= nxt_d;
            pend_q <= pend_d;
            busy_q <= step || do_adj;
        end
    end

    assign sec_o  = cur_q.sec;
    assign min_o  = cur_q.min;
    assign hour_o = cur_q.hour;
    assign pm_o   = cur_q.pm;
    assign day_o  = cur_q.day;
    assign mon_o  = cur_q.mon;
    assign year_o = cur_q.year;
    assign wday_o = cur_q.wday;
    assign busy_o = busy_q;
endmodule

// File: rtl/bcd_calendar_chk.sv
// Module bcd_calendar_chk: temporal checks on the calendar counter ports,
// bound into every bcd_calendar instance.
// Assumes ticks are spaced at least two cycles apart.
module bcd_calendar_chk
    import cal_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick_i,
    input logic                  run_i,
    input logic                  hold_i,
    input logic                  adjust_i,
    input logic [NUM_FIELDS-1:0] wr_stb_i,
    input logic [SEC_W-1:0]      sec_o,
    input logic [MIN_W-1:0]      min_o,
    input logic [HOUR_W-1:0]     hour_o,
    input logic [DAY_W-1:0]      day_o,
    input logic                  busy_o,
    input logic                  pend_q
);
    AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !tick_i && !pend_q |=> !busy_o); // R8

    AST_TICK_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && tick_i && !hold_i && !busy_o |=> busy_o); // R8

    AST_STOPPED_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i && !pend_q && !adjust_i && (wr_stb_i == '0) |=> $stable(sec_o)); // R2

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i && !adjust_i && (wr_stb_i == '0)
        |=> $stable(sec_o) && $stable(min_o) && $stable(hour_o) && $stable(day_o)); // R9

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_o == 7'h59) && run_i && tick_i && !hold_i && !busy_o && !adjust_i
        && (wr_stb_i == '0) |=> (sec_o == 7'h00)); // R3

    AST_ADJ_ZERO_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        adjust_i && !busy_o && (wr_stb_i == '0) |=> (sec_o == 7'h00)); // R10
endmodule

bind bcd_calendar bcd_calendar_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run_i),
    .hold_i(hold_i), .adjust_i(adjust_i), .wr_stb_i(wr_stb_i),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .day_o(day_o),
    .busy_o(busy_o), .pend_q(pend_q)
);

// File: tb/bcd_calendar_test.sv
// Bench for bcd_calendar: sweeps hours, minutes, seconds, month ends over
// all years, hold and adjust cases; expectations come from binary arithmetic.
module bcd_calendar_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, run = 1'b0, mode24 = 1'b0, hold = 1'b0, adj = 1'b0;
    logic [6:0] stb = '0;
    logic [7:0] wdata = '0;
    logic [6:0] sec, min;
    logic [5:0] hour, day;
    logic       pm, busy;
    logic [4:0] mon;
    logic [7:0] year;
    logic [2:0] wday;
    int total = 0, failed = 0, cyc = 0;

    always #2 clk = ~clk;

    bcd_calendar uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .run_i(run), .mode24_i(mode24),
        .hold_i(hold), .adjust_i(adj), .wr_stb_i(stb), .wr_data_i(wdata),
        .sec_o(sec), .min_o(min), .hour_o(hour), .pm_o(pm), .day_o(day),
        .mon_o(mon), .year_o(year), .wday_o(wday), .busy_o(busy));

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            total++; failed++;
            $display("FAIL watchdog (all reqs) actual=timeout expected=finish");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    function automatic logic [7:0] bcd(int n);
        return 8'((n / 10) * 16 + (n % 10));
    endfunction

    function automatic int mlen(int m, int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(int idx, logic [7:0] d);
        @(negedge clk); stb = 7'(1 << idx); wdata = d;
        @(negedge clk); stb = '0;
    endtask

    task automatic set_hms(int h, int m, int s, logic p);
        wr(2, bcd(h) | (p ? 8'h80 : 8'h00));
        wr(1, bcd(m));
        wr(0, bcd(s));
    endtask

    // Counted tick: busy must show in the following cycle, then settle.
    task automatic tick_step();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        chk("R8 busy after tick", {7'd0, busy}, 8'd1);
        @(negedge clk);
    endtask

    task automatic adj_step();
        @(negedge clk); adj = 1'b1;
        @(negedge clk); adj = 1'b0;
        chk("R8 busy after adjust", {7'd0, busy}, 8'd1);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 sec", {1'b0, sec}, 8'h00);
        chk("R1 min", {1'b0, min}, 8'h00);
        chk("R1 hour", {2'b0, hour}, 8'h12);
        chk("R1 pm", {7'd0, pm}, 8'h00);
        chk("R1 day", {2'b0, day}, 8'h01);
        chk("R1 mon", {3'b0, mon}, 8'h01);
        chk("R1 year", year, 8'h00);
        chk("R1 wday", {5'b0, wday}, 8'h00);
        chk("R1 busy", {7'd0, busy}, 8'h00);

        // R2: ticks while stopped are dropped and not remembered.
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        chk("R2 busy stopped", {7'd0, busy}, 8'h00);
        chk("R2 sec stopped", {1'b0, sec}, 8'h00);
        run = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 no late second", {1'b0, sec}, 8'h00);

        // R3: every second value, then every minute value with carry.
        mode24 = 1'b1;
        set_hms(5, 0, 0, 1'b0);
        for (int i = 0; i < 60; i++) begin
            tick_step();
            chk("R3 sec sweep", {1'b0, sec}, bcd((i + 1) % 60));
            chk("R3 min from sec", {1'b0, min}, (i == 59) ? 8'h01 : 8'h00);
        end
        for (int m = 0; m < 60; m++) begin
            set_hms(5, m, 59, 1'b0);
            tick_step();
            chk("R3 min sweep", {1'b0, min}, bcd((m + 1) % 60));
            chk("R3 sec wrap", {1'b0, sec}, 8'h00);
            chk("R3 hour carry", {2'b0, hour}, bcd(m == 59 ? 6 : 5));
        end

        // R4: 24-hour sweep of every hour.
        wr(5, 8'h00); wr(4, 8'h01);
        for (int h = 0; h < 24; h++) begin
            wr(3, 8'h05);
            set_hms(h, 59, 59, 1'b0);
            tick_step();
            chk("R4 hour 24", {2'b0, hour}, bcd((h + 1) % 24));
            chk("R4 day carry 24", {2'b0, day}, (h == 23) ? 8'h06 : 8'h05);
        end

        // R5: 12-hour sweep, both halves.
        mode24 = 1'b0;
        for (int p = 0; p < 2; p++) begin
            for (int h = 1; h <= 12; h++) begin
                wr(3, 8'h05);
                set_hms(h, 59, 59, p[0]);
                tick_step();
                chk("R5 hour 12", {2'b0, hour}, bcd(h == 12 ? 1 : h + 1));
                chk("R5 pm flag", {7'd0, pm}, {7'd0, (h == 11) ? ~p[0] : p[0]});
                chk("R5 day carry 12", {2'b0, day}, (h == 11 && p == 1) ? 8'h06 : 8'h05);
            end
        end

        // R6, R7: month end and day before it, every month of every year.
        mode24 = 1'b1;
        for (int y = 0; y < 100; y++) begin
            for (int m = 1; m <= 12; m++) begin
                for (int k = 0; k < 2; k++) begin
                    int w, d;
                    w = (y * 12 + m + k) % 7;
                    d = mlen(m, y) - 1 + k;
                    wr(5, bcd(y)); wr(4, bcd(m)); wr(3, bcd(d)); wr(6, 8'(w));
                    set_hms(23, 59, 59, 1'b0);
                    tick_step();
                    chk("R6 day", {2'b0, day}, (k == 1) ? 8'h01 : bcd(d + 1));
                    chk("R6 month", {3'b0, mon}, (k == 1) ? bcd(m % 12 + 1) : bcd(m));
                    chk("R6 year", year, (k == 1 && m == 12) ? bcd((y + 1) % 100) : bcd(y));
                    chk("R7 wday", {5'b0, wday}, 8'((w + 1) % 7));
                end
            end
        end

        // R11: direct field writes, including the PM bit and day-of-week.
        mode24 = 1'b0;
        wr(2, 8'h87);
        chk("R11 hour write", {2'b0, hour}, 8'h07);
        chk("R11 pm write", {7'd0, pm}, 8'h01);
        wr(6, 8'h03);
        chk("R11 wday write", {5'b0, wday}, 8'h03);
        mode24 = 1'b1;

        // R8: write and adjust in the busy cycle are dropped.
        set_hms(5, 10, 20, 1'b0);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0; stb = 7'b0000001; wdata = 8'h42;
        @(negedge clk); stb = '0;
        chk("R8 write while busy", {1'b0, sec}, 8'h21);
        wr(0, 8'h40);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0; adj = 1'b1;
        @(negedge clk); adj = 1'b0;
        chk("R8 adjust while busy", {1'b0, sec}, 8'h41);
        chk("R8 min untouched", {1'b0, min}, 8'h10);
        @(negedge clk);

        // R9: hold freezes, one remembered second on release.
        set_hms(5, 10, 10, 1'b0);
        @(negedge clk); hold = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            chk("R9 frozen sec", {1'b0, sec}, 8'h10);
            chk("R9 no busy in hold", {7'd0, busy}, 8'h00);
        end
        @(negedge clk); hold = 1'b0;
        @(negedge clk);
        chk("R9 release busy", {7'd0, busy}, 8'h01);
        chk("R9 release plus one", {1'b0, sec}, 8'h11);
        repeat (3) @(negedge clk);
        chk("R9 only one extra", {1'b0, sec}, 8'h11);
        hold = 1'b1;
        repeat (4) @(negedge clk);
        hold = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 release no tick", {1'b0, sec}, 8'h11);
        wr(5, 8'h99); wr(4, 8'h12); wr(3, 8'h31);
        set_hms(23, 59, 59, 1'b0);
        @(negedge clk); hold = 1'b1;
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        @(negedge clk); hold = 1'b0;
        @(negedge clk);
        chk("R9 carry sec", {1'b0, sec}, 8'h00);
        chk("R9 carry hour", {2'b0, hour}, 8'h00);
        chk("R9 carry day", {2'b0, day}, 8'h01);
        chk("R9 carry year", year, 8'h00);
        @(negedge clk);

        // R10: adjust over every seconds value, then full-carry case.
        for (int s = 0; s < 60; s++) begin
            set_hms(5, 10, s, 1'b0);
            adj_step();
            chk("R10 sec cleared", {1'b0, sec}, 8'h00);
            chk("R10 min round", {1'b0, min}, (s >= 30) ? 8'h11 : 8'h10);
        end
        wr(5, 8'h99); wr(4, 8'h12); wr(3, 8'h31);
        set_hms(23, 59, 45, 1'b0);
        adj_step();
        chk("R10 full carry min", {1'b0, min}, 8'h00);
        chk("R10 full carry hour", {2'b0, hour}, 8'h00);
        chk("R10 full carry day", {2'b0, day}, 8'h01);
        chk("R10 full carry mon", {3'b0, mon}, 8'h01);
        chk("R10 full carry year", year, 8'h00);

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule